// File: doc/BRIEF.md
# Multi-table ternary search engine

This block keeps a small array of 80-bit ternary entries and searches them against a wide lookup key. Each entry stores a value, a per-bit care mask and a valid flag. A 2-bit table tag assigns each entry to one of up to four logical tables. A cleared care bit makes that entry bit a wildcard, so the entry matches either key value at that position. This is how network prefixes are stored: the bits below the prefix length are wildcards, and a default route is an entry with every bit a wildcard.

A lookup presents one 320-bit key, split into four 80-bit segments. Segment 0 is bits 79:0 and segment 3 is bits 319:240. Each table has a 4-bit segment-select register. The selected segments are packed upward from bit 0 into that table's compacted key. Because entries are 80 bits wide, a table compares against the lowest-numbered segment it selects. All four tables are searched in the same operation, and each has its own priority encoder. Within a table, the entry with the lowest index wins. Software therefore places longer prefixes at lower indices.

Entries are written one at a time through an address/data port, and select registers through a separate small port. Results appear a fixed two cycles after the search, together with a one-cycle valid strobe.

Top module: `tcam_multi_search`

## Requirements
- R1: An entry bit whose care bit is 0 matches either key value. An entry with every care bit 0 matches every key, and so serves as the lowest-priority default when placed last in its table.
- R2: An entry whose valid flag is 0 never matches, whatever its value and mask.
- R3: When several valid entries of one table match, that table reports the lowest index among them.
- R4: An entry takes part only in the table named by its 2-bit table tag (0 to 3), and it is ignored by the other tables.
- R5: Each table compares entries against the lowest-numbered segment whose bit is set in its select register. Bit j of the register selects key bits 80*j+79 down to 80*j. A table whose select register is 0 never hits.
- R6: One search resolves all four tables at once, each from its own segment of the same key, and each reports its own hit flag and index.
- R7: A search issued with `srch_en` in cycle n produces `rslt_valid` high for exactly one cycle, in cycle n+2. Back-to-back searches give back-to-back results in issue order.
- R8: A table that does not hit reports index 0. While `rslt_valid` is low, all hit flags and indexes are 0.
- R9: After reset, every entry is invalid, every select register is 4'b0001 (segment 0), and the result outputs are 0.
- R10: For the prefixes /20 (0001 1101 0101 1110 1101), /13 (0010 1100 0011 0) and /8 (0001 1101), stored at indices 0, 1 and 2, and an all-wildcard default at index 3, the address 0001 1101 0101 1110 1101 1100 1000 0110 resolves to index 0.
- R11: A write and a search never share a cycle. A write affects searches issued in later cycles, but not the result of a search issued earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write one entry |
| wr_addr | input | 4 | Entry index to write |
| wr_value | input | 80 | Entry value |
| wr_care | input | 80 | Care mask, 1 = compare this bit, 0 = wildcard |
| wr_valid | input | 1 | Valid flag stored with the entry |
| wr_table | input | 2 | Table tag stored with the entry |
| sel_wr_en | input | 1 | Write one table's segment-select register |
| sel_wr_table | input | 2 | Table whose select register is written |
| sel_wr_mask | input | 4 | New segment-select value |
| srch_en | input | 1 | Issue a search this cycle |
| srch_key | input | 320 | Search key, four 80-bit segments |
| rslt_valid | output | 1 | Result strobe, two cycles after the search |
| rslt_hit | output | 4 | Per-table hit flag, bit t for table t |
| rslt_idx | output | 16 | Per-table winning index, bits 4t+3:4t for table t |

## Verification
An entry whose stored valid flag, tag, mask or value is wrong shows up as a wrong hit flag or index. It appears on the very next search that selects that table's segment, two cycles after issue, so each scenario writes entries and then immediately searches keys that only that state would separate. A wrong select register moves a table's hit to a different key segment. A priority encoder scanning the wrong way reports a higher index whenever two entries of one table overlap. A lost or doubled pipeline stage shifts or drops the valid strobe, which the result queue detects as a count or ordering mismatch.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
   localparam int MAX_TABLES = 4;

   function automatic int clog2_min1(input int v);
      int w;
      w = 1;
      while ((1 << w) < v) w++;
      return w;
   endfunction
endpackage

// File: rtl/tcam_key_select.sv
module tcam_key_select #(
   parameter int N_SEG    = 4,
   parameter int SEG_W    = 80,
   parameter int N_TABLES = 4,
   parameter int TID_W    = 2
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic                               sel_wr_en,
   input  logic [TID_W-1:0]                   sel_wr_table,
   input  logic [N_SEG-1:0]                   sel_wr_mask,
   input  logic [N_SEG*SEG_W-1:0]             srch_key,
   output logic [N_TABLES-1:0][SEG_W-1:0]     table_key,
   output logic [N_TABLES-1:0]                table_en
);
   logic [N_TABLES-1:0][N_SEG-1:0] sel_q;

   genvar t;
   generate
      for (t = 0; t < N_TABLES; t++) begin : g_tbl
         always_ff @(posedge clk) begin
            if (rst)
               sel_q[t] <= N_SEG'(1);
            else if (sel_wr_en && sel_wr_table == TID_W'(t))
               sel_q[t] <= sel_wr_mask;
         end

         // lowest selected segment lands in the packed key's bottom slot
         always_comb begin
            table_key[t] = '0;
            for (int j = N_SEG - 1; j >= 0; j--) begin
               if (sel_q[t][j]) table_key[t] = srch_key[j*SEG_W +: SEG_W];
            end
            table_en[t] = |sel_q[t];
         end
      end
   endgenerate
endmodule

// File: rtl/tcam_entry_array.sv
module tcam_entry_array #(
   parameter int N_ENTRIES = 16,
   parameter int SEG_W     = 80,
   parameter int N_TABLES  = 4,
   parameter int IDX_W     = 4,
   parameter int TID_W     = 2
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic                               wr_en,
   input  logic [IDX_W-1:0]                   wr_addr,
   input  logic [SEG_W-1:0]                   wr_value,
   input  logic [SEG_W-1:0]                   wr_care,
   input  logic                               wr_valid,
   input  logic [TID_W-1:0]                   wr_table,
   input  logic [N_TABLES-1:0][SEG_W-1:0]     table_key,
   output logic [N_TABLES-1:0][N_ENTRIES-1:0] raw_hit
);
   genvar e, t;
   generate
      for (e = 0; e < N_ENTRIES; e++) begin : g_ent
         logic [SEG_W-1:0] val_q;
         logic [SEG_W-1:0] care_q;
         logic             vld_q;
         logic [TID_W-1:0] tid_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               val_q  <= '0;
               care_q <= '0;
               vld_q  <= 1'b0;
               tid_q  <= '0;
            end else if (wr_en && wr_addr == IDX_W'(e)) begin
               val_q  <= wr_value;
               care_q <= wr_care;
               vld_q  <= wr_valid;
               tid_q  <= wr_table;
            end
         end

         for (t = 0; t < N_TABLES; t++) begin : g_cmp
            assign raw_hit[t][e] = vld_q && (tid_q == TID_W'(t)) &&
                                   (((table_key[t] ^ val_q) & care_q) == '0);
         end
      end
   endgenerate
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
   parameter int N         = 16,
   parameter int IDX_W     = 4,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   assign any = |req;

   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) idx = IDX_W'(i);
            end
         end
      end else begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++) begin
               if (req[i]) idx = IDX_W'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tcam_multi_search.sv
module tcam_multi_search
   import tcam_pkg::*;
#(
   parameter int N_ENTRIES = 16,
   parameter int SEG_W     = 80,
   parameter int N_SEG     = 4,
   parameter int N_TABLES  = 4,
   parameter bit LOW_FIRST = 1'b1,
   localparam int IDX_W    = clog2_min1(N_ENTRIES),
   localparam int TID_W    = clog2_min1(N_TABLES),
   localparam int KEY_W    = N_SEG * SEG_W
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_addr,
   input  logic [SEG_W-1:0]          wr_value,
   input  logic [SEG_W-1:0]          wr_care,
   input  logic                      wr_valid,
   input  logic [TID_W-1:0]          wr_table,
   input  logic                      sel_wr_en,
   input  logic [TID_W-1:0]          sel_wr_table,
   input  logic [N_SEG-1:0]          sel_wr_mask,
   input  logic                      srch_en,
   input  logic [KEY_W-1:0]          srch_key,
   output logic                      rslt_valid,
   output logic [N_TABLES-1:0]       rslt_hit,
   output logic [N_TABLES*IDX_W-1:0] rslt_idx
);
   generate
      if (N_TABLES < 1 || N_TABLES > MAX_TABLES) begin : g_bad_tables
         $error("tcam_multi_search: N_TABLES must be 1..4");
      end
      if (N_ENTRIES < 2) begin : g_bad_entries
         $error("tcam_multi_search: N_ENTRIES must be at least 2");
      end
      if (N_SEG < 1) begin : g_bad_seg
         $error("tcam_multi_search: N_SEG must be at least 1");
      end
   endgenerate

   logic [N_TABLES-1:0][SEG_W-1:0]     table_key;
   logic [N_TABLES-1:0]                table_en;
   logic [N_TABLES-1:0][N_ENTRIES-1:0] raw_hit;

   tcam_key_select #(
      .N_SEG(N_SEG), .SEG_W(SEG_W), .N_TABLES(N_TABLES), .TID_W(TID_W)
   ) u_keysel (
      .clk(clk), .rst(rst),
      .sel_wr_en(sel_wr_en), .sel_wr_table(sel_wr_table), .sel_wr_mask(sel_wr_mask),
      .srch_key(srch_key), .table_key(table_key), .table_en(table_en)
   );

   tcam_entry_array #(
      .N_ENTRIES(N_ENTRIES), .SEG_W(SEG_W), .N_TABLES(N_TABLES),
      .IDX_W(IDX_W), .TID_W(TID_W)
   ) u_array (
      .clk(clk), .rst(rst),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_value(wr_value), .wr_care(wr_care),
      .wr_valid(wr_valid), .wr_table(wr_table),
      .table_key(table_key), .raw_hit(raw_hit)
   );

   // stage 1: captured match vectors
   logic                               s1_vld;
   logic [N_TABLES-1:0][N_ENTRIES-1:0] s1_vec;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_vld <= 1'b0;
         s1_vec <= '0;
      end else begin
         s1_vld <= srch_en;
         for (int t = 0; t < N_TABLES; t++)
            s1_vec[t] <= (srch_en && table_en[t]) ? raw_hit[t] : '0;
      end
   end

   // stage 2: per-table priority encode
   logic [N_TABLES-1:0]            enc_any;
   logic [N_TABLES-1:0][IDX_W-1:0] enc_idx;

   genvar g;
   generate
      for (g = 0; g < N_TABLES; g++) begin : g_enc
         tcam_prio_enc #(
            .N(N_ENTRIES), .IDX_W(IDX_W), .LOW_FIRST(LOW_FIRST)
         ) u_enc (
            .req(s1_vec[g]), .any(enc_any[g]), .idx(enc_idx[g])
         );
      end
   endgenerate

   logic [N_TABLES-1:0][IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         rslt_valid <= 1'b0;
         rslt_hit   <= '0;
         idx_q      <= '0;
      end else begin
         rslt_valid <= s1_vld;
         rslt_hit   <= s1_vld ? enc_any : '0;
         idx_q      <= s1_vld ? enc_idx : '0;
      end
   end

   assign rslt_idx = idx_q;
endmodule

// File: rtl/tcam_multi_search_chk.sv
module tcam_multi_search_chk #(
   parameter int N_TABLES = 4,
   parameter int IDX_W    = 4
) (
   input logic                      clk,
   input logic                      rst,
   input logic                      srch_en,
   input logic                      wr_en,
   input logic                      sel_wr_en,
   input logic                      rslt_valid,
   input logic [N_TABLES-1:0]       rslt_hit,
   input logic [N_TABLES*IDX_W-1:0] rslt_idx
);
   logic [1:0] cyc;

   always_ff @(posedge clk) begin
      if (rst)             cyc <= 2'd0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   // R7: strobe exactly two cycles after issue
   a_r7_two_cycle: assert property (@(posedge clk) disable iff (rst)
      (cyc >= 2'd2) |-> (rslt_valid == $past(srch_en, 2)));

   // R11: no write in a search cycle
   a_r11_no_write_with_search: assert property (@(posedge clk) disable iff (rst)
      srch_en |-> !(wr_en || sel_wr_en));

   // R8: outputs quiet between results
   a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
      !rslt_valid |-> (rslt_hit == '0 && rslt_idx == '0));

   // R9: reset clears results
   a_r9_reset_clear: assert property (@(posedge clk)
      $past(rst) |-> (!rslt_valid && rslt_hit == '0));

   genvar t;
   generate
      for (t = 0; t < N_TABLES; t++) begin : g_miss
         // R8: a miss reports index 0
         a_r8_miss_idx0: assert property (@(posedge clk) disable iff (rst)
            !rslt_hit[t] |-> (rslt_idx[t*IDX_W +: IDX_W] == '0));
      end
   endgenerate
endmodule

bind tcam_multi_search tcam_multi_search_chk #(
   .N_TABLES(N_TABLES), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst(rst), .srch_en(srch_en), .wr_en(wr_en), .sel_wr_en(sel_wr_en),
   .rslt_valid(rslt_valid), .rslt_hit(rslt_hit), .rslt_idx(rslt_idx)
);

// File: tb/tcam_multi_search_test.sv
`timescale 1ns/1ps
module tcam_multi_search_test;
   localparam int NE = 16;
   localparam int SW = 80;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic [3:0]    wr_addr = '0;
   logic [79:0]   wr_value = '0;
   logic [79:0]   wr_care = '0;
   logic          wr_valid = 1'b0;
   logic [1:0]    wr_table = '0;
   logic          sel_wr_en = 1'b0;
   logic [1:0]    sel_wr_table = '0;
   logic [3:0]    sel_wr_mask = '0;
   logic          srch_en = 1'b0;
   logic [319:0]  srch_key = '0;
   logic          rslt_valid;
   logic [3:0]    rslt_hit;
   logic [15:0]   rslt_idx;

   tcam_multi_search uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_value(wr_value),
      .wr_care(wr_care), .wr_valid(wr_valid), .wr_table(wr_table),
      .sel_wr_en(sel_wr_en), .sel_wr_table(sel_wr_table), .sel_wr_mask(sel_wr_mask),
      .srch_en(srch_en), .srch_key(srch_key),
      .rslt_valid(rslt_valid), .rslt_hit(rslt_hit), .rslt_idx(rslt_idx)
   );

   always #10 clk = ~clk;

   typedef struct {
      logic [3:0]  hit;
      logic [15:0] idx;
      string       tag;
   } exp_t;

   exp_t        expq[$];
   int          nvec = 0;
   int          nerr = 0;
   int          nsearch = 0;
   int          nresult = 0;
   bit          done = 1'b0;

   // shadow of written state
   logic [79:0] sh_val  [NE];
   logic [79:0] sh_care [NE];
   logic        sh_vld  [NE];
   logic [1:0]  sh_tid  [NE];
   logic [3:0]  sh_sel  [4];

   function automatic exp_t predict(input logic [319:0] k, input string tag);
      exp_t r;
      r.hit = '0;
      r.idx = '0;
      r.tag = tag;
      for (int t = 0; t < 4; t++) begin
         logic [79:0] tk;
         bit          en;
         tk = '0;
         en = 1'b0;
         for (int j = 3; j >= 0; j--) begin
            if (sh_sel[t][j]) begin
               tk = k[j*SW +: SW];
               en = 1'b1;
            end
         end
         if (en) begin
            for (int e = NE - 1; e >= 0; e--) begin
               if (sh_vld[e] && sh_tid[e] == 2'(t) &&
                   ((tk ^ sh_val[e]) & sh_care[e]) == '0) begin
                  r.hit[t] = 1'b1;
                  r.idx[t*4 +: 4] = 4'(e);
               end
            end
         end
      end
      return r;
   endfunction

   function automatic logic [319:0] mk_key(input logic [79:0] s3, input logic [79:0] s2,
                                           input logic [79:0] s1, input logic [79:0] s0);
      return {s3, s2, s1, s0};
   endfunction

   task automatic wr_entry(input int e, input logic [1:0] tid, input logic [79:0] v,
                           input logic [79:0] c, input logic vld);
      @(negedge clk);
      srch_en   = 1'b0;
      sel_wr_en = 1'b0;
      wr_en     = 1'b1;
      wr_addr   = 4'(e);
      wr_table  = tid;
      wr_value  = v;
      wr_care   = c;
      wr_valid  = vld;
      sh_val[e] = v;  sh_care[e] = c;  sh_vld[e] = vld;  sh_tid[e] = tid;
   endtask

   task automatic wr_sel(input int t, input logic [3:0] m);
      @(negedge clk);
      srch_en      = 1'b0;
      wr_en        = 1'b0;
      sel_wr_en    = 1'b1;
      sel_wr_table = 2'(t);
      sel_wr_mask  = m;
      sh_sel[t]    = m;
   endtask

   task automatic do_search(input logic [319:0] k, input string tag);
      @(negedge clk);
      wr_en     = 1'b0;
      sel_wr_en = 1'b0;
      srch_en   = 1'b1;
      srch_key  = k;
      expq.push_back(predict(k, tag));
      nsearch++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         wr_en     = 1'b0;
         sel_wr_en = 1'b0;
         srch_en   = 1'b0;
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!rst && !done && rslt_valid) begin
         nresult++;
         if (expq.size() == 0) begin
            nvec++; nerr++;
            $display("FAIL R7: unexpected result strobe, actual valid=1 expected valid=0");
         end else begin
            exp_t x;
            x = expq.pop_front();
            for (int t = 0; t < 4; t++) begin
               nvec++;
               if (rslt_hit[t] !== x.hit[t] || rslt_idx[t*4 +: 4] !== x.idx[t*4 +: 4]) begin
                  nerr++;
                  $display("FAIL %s table %0d: actual hit=%b idx=%0d, expected hit=%b idx=%0d",
                           x.tag, t, rslt_hit[t], rslt_idx[t*4 +: 4], x.hit[t], x.idx[t*4 +: 4]);
               end
            end
         end
      end
   end

   initial begin
      #4_000_000;
      if (!done) begin
         done = 1'b1;
         nvec++; nerr++;
         $display("FAIL watchdog: actual run still busy, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

   localparam logic [79:0] CARE32 = {48'h0, 32'hFFFF_FFFF};
   localparam logic [79:0] ALLC   = {80{1'b1}};
   localparam logic [79:0] VA = 80'hA1A1_0000_1111_2222_3333;
   localparam logic [79:0] VB = 80'hB2B2_4444_5555_6666_7777;
   localparam logic [79:0] VC = 80'hC3C3_8888_9999_AAAA_BBBB;
   localparam logic [79:0] VD = 80'hD4D4_CCCC_DDDD_EEEE_FFFF;
   localparam logic [79:0] VE = 80'hE5E5_1234_5678_0000_0000;
   localparam logic [79:0] VZ = 80'h0F0F_0F0F_0F0F_0F0F_0F0F;

   initial begin
      for (int e = 0; e < NE; e++) begin
         sh_val[e] = '0; sh_care[e] = '0; sh_vld[e] = 1'b0; sh_tid[e] = '0;
      end
      for (int t = 0; t < 4; t++) sh_sel[t] = 4'b0001;

      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R9: reset state of results
      nvec++;
      if (rslt_valid !== 1'b0 || rslt_hit !== 4'b0 || rslt_idx !== 16'h0) begin
         nerr++;
         $display("FAIL R9: actual valid=%b hit=%b idx=%h, expected 0 0 0",
                  rslt_valid, rslt_hit, rslt_idx);
      end
      // R9: all entries invalid after reset
      do_search(mk_key(VZ, VZ, VZ, 80'h0), "R9");

      // table 0: prefix entries ordered longest first
      wr_entry(0, 2'd0, {48'h0, 32'h1D5E_D000}, {48'h0, 32'hFFFF_F000}, 1'b1);
      wr_entry(1, 2'd0, {48'h0, 32'h2C30_0000}, {48'h0, 32'hFFF8_0000}, 1'b1);
      wr_entry(2, 2'd0, {48'h0, 32'h1D00_0000}, {48'h0, 32'hFF00_0000}, 1'b1);
      wr_entry(3, 2'd0, 80'h0, 80'h0, 1'b1);
      do_search(mk_key(VZ, VZ, VZ, {48'h0, 32'h1D5E_DC86}), "R10");
      do_search(mk_key(VZ, VZ, VZ, {48'h0, 32'h1D00_0000}), "R3");
      do_search(mk_key(VZ, VZ, VZ, {48'h0, 32'h2C31_2345}), "R1");
      do_search(mk_key(VZ, VZ, VZ, {48'hFFFF, 32'hFFFF_FFFF}), "R1");

      // other tables
      wr_sel(1, 4'b0100);
      wr_sel(2, 4'b1010);
      wr_sel(3, 4'b0000);
      wr_entry(4, 2'd1, VA, ALLC, 1'b1);
      wr_entry(5, 2'd1, VB, ALLC, 1'b1);
      wr_entry(6, 2'd1, VC, ALLC, 1'b0);
      wr_entry(7, 2'd2, VD, ALLC, 1'b1);
      wr_entry(8, 2'd3, 80'h0, 80'h0, 1'b1);
      wr_entry(9, 2'd1, VE, ALLC, 1'b1);
      do_search(mk_key(VB, VA, VD, {48'h0, 32'h1D5E_DC86}), "R6");
      do_search(mk_key(VZ, VB, VZ, VZ), "R6");
      do_search(mk_key(VZ, VC, VZ, VZ), "R2");
      do_search(mk_key(VZ, VE, VZ, VE), "R4");
      do_search(mk_key(VD, VZ, VA, VZ), "R5");
      wr_sel(3, 4'b1000);
      do_search(mk_key(VZ, VZ, VZ, VZ), "R5");

      // priority among overlapping entries of one table
      wr_entry(10, 2'd1, VA, CARE32, 1'b1);
      do_search(mk_key(VZ, VA, VZ, VZ), "R3");
      wr_entry(4, 2'd1, VA, ALLC, 1'b0);
      do_search(mk_key(VZ, VA, VZ, VZ), "R3");

      // R11: write after an issued search leaves that result alone
      do_search(mk_key(VZ, VA, VZ, VZ), "R11");
      wr_entry(10, 2'd1, VA, CARE32, 1'b0);
      do_search(mk_key(VZ, VA, VZ, VZ), "R11");

      // R7: back-to-back searches come back in order
      do_search(mk_key(VZ, VB, VD, {48'h0, 32'h1D00_0000}), "R7");
      do_search(mk_key(VZ, VE, VZ, {48'h0, 32'h2C30_0001}), "R7");
      do_search(mk_key(VD, VC, VD, VZ), "R7");
      do_search(mk_key(VZ, VA, VZ, {48'h0, 32'h1D5E_D000}), "R7");
      idle(6);

      nvec++;
      if (nresult != nsearch || expq.size() != 0) begin
         nerr++;
         $display("FAIL R7: actual results=%0d pending=%0d, expected results=%0d pending=0",
                  nresult, expq.size(), nsearch);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule